// File: doc/BRIEF.md
# Per-Row Palette Raster Scan-Out

This block turns row records held in video memory into a stream of 12-bit pixels for a raster whose monitor is turned on its side, so that each record is drawn as one display line. Each record is 256 bytes long. Its first 32 bytes are a private 16-colour palette for that record. The remaining 224 bytes hold two 4-bit colour indices each, which gives 448 pixel slots. Only the first `SHOWN` slots are ever presented as valid pixels.

For every line, the block first reads the record's palette into local registers. It then walks the pixel bytes and looks up each index in that palette. A CPU-written row register sets the record shown on line 0 of a frame, and line L shows record (base + L) modulo the number of rows. The value is picked up only at a frame boundary. Two vertical configurations are covered by the `VIS_LAST` parameter: 244 by default, 239 for the shorter screen.

Top module: `rps_scanout`

## Requirements
- R1: A memory read for byte b of record r drives address {r, b}, with b in the low 8 bits. The data is taken on `mem_rdata_i` in the cycle after `mem_rd_o`.
- R2: Palette entry k is byte 2k followed by byte 2k+1 of the record. Red is bits [3:0] of byte 2k, and the upper four bits of that byte are ignored. Green is bits [7:4] of byte 2k+1 and blue is bits [3:0] of byte 2k+1.
- R3: Pixel byte 32+j supplies slot 2j from its bits [7:4] and slot 2j+1 from its bits [3:0]. A pixel byte is read at most once every two cycles.
- R4: Slots from `SHOWN` up to 447 are never valid. Whenever `pix_valid_o` is low, the colour outputs are zero.
- R5: Every line uses the palette of its own record, and all 16 entries are loaded before slot 0 of that line is looked up.
- R6: On lines above `VIS_LAST`, no pixel is valid and no memory read is issued. A visible line issues exactly 256 reads.
- R7: A row write updates the held register at once. The frame base takes that value at the next frame boundary, and line L reads record (base + L) mod `ROWS`.
- R8: `line_start_o` pulses for one cycle with slot 0 of every line. `frame_start_o` pulses with it on line 0 only, after `LINES` line pulses.
- R9: A line lasts 482 cycles. Slots are output one per cycle in ascending order, starting at the line pulse.
- R10: While reset is held, the valid, colour and marker outputs are zero and the frame base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| row_we_i | input | 1 | Row register write strobe |
| row_wdata_i | input | ROW_W | Row register write value |
| mem_rd_o | output | 1 | Video memory read request |
| mem_addr_o | output | ROW_W+8 | Read address {record, byte} |
| mem_rdata_i | input | 8 | Read data, one cycle after request |
| pix_valid_o | output | 1 | Pixel valid |
| pix_r_o | output | 4 | Red |
| pix_g_o | output | 4 | Green |
| pix_b_o | output | 4 | Blue |
| line_start_o | output | 1 | Slot 0 of a line |
| frame_start_o | output | 1 | Slot 0 of line 0 |

## Verification
Memory is filled with a hash of row and byte, so every record carries a different palette and the ignored upper bits of red bytes are non-zero. This separates the per-row palette from a shared table and shows whether those bits are masked. Every valid pixel is compared against a model built from the record bytes, which tells apart nibble order, entry byte order and off-by-one slot or byte addressing. Three row bases are used: 0, a mid value written during frame 0, and a value near the top written during frame 1. Together they show that the base is held until the frame boundary and that record numbers wrap. Per-line valid counts, line spacing and per-frame read counts separate hidden slots, blank lines and marker placement.

// File: rtl/rps_pkg.sv
package rps_pkg;
  localparam int PAL_ENTRIES = 16;
  localparam int PAL_BYTES   = 2 * PAL_ENTRIES;
  localparam int REC_BYTES   = 256;
  localparam int PIX_BYTES   = REC_BYTES - PAL_BYTES;
  localparam int SLOTS       = 2 * PIX_BYTES;
  localparam int LINE_CYC    = PAL_BYTES + SLOTS + 2;
  localparam int CYC_W       = $clog2(LINE_CYC);
  localparam int SLOT_W      = $clog2(SLOTS);

  typedef struct packed {
    logic [3:0] r;
    logic [3:0] g;
    logic [3:0] b;
  } rgb_t;
endpackage

// File: rtl/rps_timer.sv
module rps_timer
  import rps_pkg::*;
#(
  parameter int LINES  = 256,
  parameter int LINE_W = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [CYC_W-1:0]  cyc_o,
  output logic [LINE_W-1:0] line_o,
  output logic              frame_end_o
);
  localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(LINE_CYC - 1);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic eol;
  assign eol         = (cyc_o == CYC_LAST);
  assign frame_end_o = eol && (line_o == LINE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_o  <= '0;
      line_o <= '0;
    end else if (eol) begin
      cyc_o  <= '0;
      line_o <= frame_end_o ? '0 : line_o + 1'b1;
    end else begin
      cyc_o <= cyc_o + 1'b1;
    end
  end
endmodule

// File: rtl/rps_palette.sv
module rps_palette
  import rps_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [4:0] widx_i,
  input  logic [7:0] wdata_i,
  input  logic [3:0] ridx_i,
  output rgb_t       rgb_o
);
  logic [3:0] red_tmp;
  rgb_t       ent_q [PAL_ENTRIES];

  // even byte carries red; the entry is committed on the odd byte
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                red_tmp <= '0;
    else if (we_i && !widx_i[0]) red_tmp <= wdata_i[3:0];
  end

  for (genvar k = 0; k < PAL_ENTRIES; k++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ent_q[k] <= '0;
      else if (we_i && widx_i[0] && (widx_i[4:1] == 4'(k)))
        ent_q[k] <= rgb_t'({red_tmp, wdata_i});
    end
  end

  assign rgb_o = ent_q[ridx_i];
endmodule

// File: rtl/rps_scanout.sv
module rps_scanout
  import rps_pkg::*;
#(
  parameter int ROWS     = 256,
  parameter int LINES    = 256,
  parameter int VIS_LAST = 244,
  parameter int SHOWN    = 360,
  parameter int ROW_W    = $clog2(ROWS),
  parameter int AW       = ROW_W + 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             row_we_i,
  input  logic [ROW_W-1:0] row_wdata_i,
  output logic             mem_rd_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             pix_valid_o,
  output logic [3:0]       pix_r_o,
  output logic [3:0]       pix_g_o,
  output logic [3:0]       pix_b_o,
  output logic             line_start_o,
  output logic             frame_start_o
);
  localparam int LINE_W = $clog2(LINES);
  localparam logic [LINE_W-1:0] VIS_L   = LINE_W'(VIS_LAST);
  localparam logic [SLOT_W-1:0] SHOWN_L = SLOT_W'(SHOWN);
  localparam logic [CYC_W-1:0]  PIX0    = CYC_W'(PAL_BYTES);
  localparam logic [CYC_W-1:0]  PIXEND  = CYC_W'(PAL_BYTES + SLOTS);

  logic [CYC_W-1:0]  cyc;
  logic [LINE_W-1:0] line;
  logic              frame_end;

  rps_timer #(.LINES(LINES), .LINE_W(LINE_W)) u_timer (
    .clk_i, .rst_ni, .cyc_o(cyc), .line_o(line), .frame_end_o(frame_end)
  );

  // row register and per-frame base
  logic [ROW_W-1:0] row_sel_q, base_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_sel_q <= '0;
      base_q    <= '0;
    end else begin
      if (row_we_i)  row_sel_q <= row_wdata_i;
      if (frame_end) base_q    <= row_sel_q;
    end
  end

  // stage A: address issue
  logic              line_vis, in_pal, in_pix;
  logic [SLOT_W-1:0] slot_a;
  logic [7:0]        byte_a;
  logic [ROW_W-1:0]  row_a;

  assign line_vis = (line <= VIS_L);
  assign in_pal   = (cyc < PIX0);
  assign in_pix   = (cyc >= PIX0) && (cyc < PIXEND);
  assign slot_a   = SLOT_W'(cyc - PIX0);
  assign byte_a   = in_pal ? cyc[7:0] : 8'(PAL_BYTES) + 8'(slot_a >> 1);
  assign row_a    = base_q + ROW_W'(line);

  assign mem_rd_o   = line_vis && (in_pal || (in_pix && !slot_a[0]));
  assign mem_addr_o = {row_a, byte_a};

  // stage B: data return
  logic              b_pal, b_pix, b_vis, b_sol, b_sof;
  logic [SLOT_W-1:0] b_slot;
  logic [4:0]        b_idx;
  logic [3:0]        lo_q, nib;
  rgb_t              pal_rgb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_pal  <= 1'b0;
      b_pix  <= 1'b0;
      b_vis  <= 1'b0;
      b_sol  <= 1'b0;
      b_sof  <= 1'b0;
      b_slot <= '0;
      b_idx  <= '0;
    end else begin
      b_pal  <= line_vis && in_pal;
      b_pix  <= in_pix;
      b_vis  <= line_vis;
      b_sol  <= in_pix && (slot_a == '0);
      b_sof  <= in_pix && (slot_a == '0) && (line == '0);
      b_slot <= slot_a;
      b_idx  <= cyc[4:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           lo_q <= '0;
    else if (b_pix && b_vis && !b_slot[0]) lo_q <= mem_rdata_i[3:0];
  end

  assign nib = b_slot[0] ? lo_q : mem_rdata_i[7:4];

  rps_palette u_pal (
    .clk_i, .rst_ni,
    .we_i(b_pal), .widx_i(b_idx), .wdata_i(mem_rdata_i),
    .ridx_i(nib), .rgb_o(pal_rgb)
  );

  // stage C: output register
  logic show;
  rgb_t rgb_q;
  assign show = b_pix && b_vis && (b_slot < SHOWN_L);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o   <= 1'b0;
      rgb_q         <= '0;
      line_start_o  <= 1'b0;
      frame_start_o <= 1'b0;
    end else begin
      pix_valid_o   <= show;
      rgb_q         <= show ? pal_rgb : '0;
      line_start_o  <= b_sol;
      frame_start_o <= b_sof;
    end
  end

  assign pix_r_o = rgb_q.r;
  assign pix_g_o = rgb_q.g;
  assign pix_b_o = rgb_q.b;
endmodule

module rps_sva #(
  parameter int AW     = 16,
  parameter int LINE_W = 8,
  parameter int VIS_LAST = 244
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_rd_i,
  input logic [AW-1:0]     mem_addr_i,
  input logic              valid_i,
  input logic [11:0]       rgb_i,
  input logic              sol_i,
  input logic              sof_i,
  input logic [LINE_W-1:0] line_i
);
  localparam logic [LINE_W-1:0] VIS_L = LINE_W'(VIS_LAST);

  a_r6_no_read_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_i > VIS_L) |-> !mem_rd_i);
  a_r4_blank_black: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (rgb_i == 12'h000));
  a_r3_byte_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_i && (mem_addr_i[7:0] >= 8'd32)) |=> !mem_rd_i);
  a_r8_sof_with_sol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |-> sol_i);
  a_r8_sol_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sol_i |=> !sol_i);
  a_r9_valid_rise_on_sol: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> sol_i);
endmodule

bind rps_scanout rps_sva #(.AW(AW), .LINE_W(LINE_W), .VIS_LAST(VIS_LAST)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .mem_rd_i(mem_rd_o), .mem_addr_i(mem_addr_o),
  .valid_i(pix_valid_o), .rgb_i({pix_r_o, pix_g_o, pix_b_o}),
  .sol_i(line_start_o), .sof_i(frame_start_o), .line_i(line)
);

// File: tb/rps_scanout_tb.sv
module rps_scanout_tb;
  localparam int ROWS = 8, LINES = 6, VIS_LAST = 3, SHOWN = 360;
  localparam int ROW_W = $clog2(ROWS), AW = ROW_W + 8;
  localparam int LINE_CYC = 482;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic row_we = 1'b0;
  logic [ROW_W-1:0] row_wdata = '0;
  logic mem_rd;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic valid, sol, sof;
  logic [3:0] r, g, b;

  always #10 clk = ~clk;

  rps_scanout #(.ROWS(ROWS), .LINES(LINES), .VIS_LAST(VIS_LAST), .SHOWN(SHOWN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .row_we_i(row_we), .row_wdata_i(row_wdata),
    .mem_rd_o(mem_rd), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .pix_valid_o(valid), .pix_r_o(r), .pix_g_o(g), .pix_b_o(b),
    .line_start_o(sol), .frame_start_o(sof)
  );

  logic [7:0] mem [ROWS*256];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  int n_chk = 0, n_bad = 0;
  int sof_cnt = 0;
  bit done = 1'b0;
  logic [11:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] hashb(input int row, input int bt);
    return 8'((row * 37) ^ (bt * 11) ^ ((bt >> 3) * 91) ^ (row << 5));
  endfunction

  function automatic logic [11:0] ref_pix(input int row, input int p);
    logic [7:0] pb, hi, lo;
    int nb;
    pb = mem[row*256 + 32 + p/2];
    nb = (p % 2 == 1) ? int'(pb[3:0]) : int'(pb[7:4]);
    hi = mem[row*256 + 2*nb];
    lo = mem[row*256 + 2*nb + 1];
    return {hi[3:0], lo};
  endfunction

  task automatic push_frame(input int base);
    for (int ln = 0; ln <= VIS_LAST; ln++)
      for (int p = 0; p < SHOWN; p++)
        exp_q.push_back(ref_pix((base + ln) % ROWS, p));
  endtask

  task automatic write_row(input int v);
    @(negedge clk);
    row_we = 1'b1;
    row_wdata = ROW_W'(v);
    @(negedge clk);
    row_we = 1'b0;
  endtask

  // monitor
  int gap = 0, vcnt = 0, line_ix = 0, rd_cnt = 0;
  bit sol_seen = 1'b0;
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      gap++;
      if (sol) begin
        if (sol_seen) begin
          chk(gap == LINE_CYC, "R9 line period", gap, LINE_CYC);
          chk(vcnt == ((line_ix <= VIS_LAST) ? SHOWN : 0),
              (line_ix <= VIS_LAST) ? "R4 valid per line" : "R6 valid per line",
              vcnt, (line_ix <= VIS_LAST) ? SHOWN : 0);
        end
        if (sof) begin
          if (sol_seen) chk(line_ix == LINES - 1, "R8 frame pulse spacing", line_ix, LINES - 1);
          if (sof_cnt >= 1)
            chk(rd_cnt == (VIS_LAST + 1) * 256, "R6 reads per frame", rd_cnt, (VIS_LAST + 1) * 256);
          rd_cnt = 0;
          line_ix = 0;
          sof_cnt++;
        end else begin
          line_ix++;
        end
        sol_seen = 1'b1;
        gap = 0;
        vcnt = 0;
      end
      if (mem_rd) rd_cnt++;
      if (valid) begin
        vcnt++;
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected pixel", {r, g, b}, 0);
        else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          chk({r, g, b} == e, "R1 R2 R3 R5 R7 pixel", {r, g, b}, e);
        end
      end else begin
        chk({r, g, b} == 12'h000, "R4 R6 blank colour", {r, g, b}, 0);
      end
    end
  end

  initial begin
    for (int i = 0; i < ROWS * 256; i++) mem[i] = hashb(i / 256, i % 256);
    push_frame(0);
    repeat (3) begin
      @(negedge clk);
      chk(!valid && !sol && !sof && ({r, g, b} == 12'h000), "R10 reset outputs",
          {valid, sol, sof, r, g, b}, 0);
    end
    rst_ni = 1'b1;
    repeat (100) @(negedge clk);
    write_row(3);
    push_frame(3);
    wait (sof_cnt >= 2);
    write_row(6);
    push_frame(6);
    push_frame(6);
    wait (sof_cnt >= 4);
    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
    done = 1'b1;
    chk(exp_q.size() == 0, "R7 pending pixels", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", sof_cnt, 4);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule